// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Mask

This block collects interrupt requests from three external pins and from a parameterized set of internal peripheral sources. Every request carries a two-bit priority level, where 0 is the lowest and 3 is the highest. A request competes only if the current mask level lets it through. Among the requests that compete, the block picks one winner. It then presents the winner's identity, its level and its vector address to the processor's exception logic. That logic answers with a single-cycle acknowledge, which retires an edge-latched request.

Two of the external pins carry general requests. Each of them can be set to level-sensitive or falling-edge mode. The third pin is the non-maskable request. It always works on falling edges and always has level 3. The same three pins also select the operating mode. Their values are captured once, on the first clock edge after reset is released.

Peripheral sources hold their own request and level, and they supply their own vector. The three external sources use vectors fixed by parameters.

Top module: `irq_arbiter`

## Requirements
- R1: A request at level 0, 1 or 2 is accepted only when its level is greater than or equal to `mask_lvl`.
- R2: A level-3 request is accepted at every mask value. With `mask_lvl` = 3, requests at levels 0 to 2 are all refused.
- R3: Among accepted requests, the one with the highest level wins.
- R4: Ties at one level are broken by source identifier, lowest first. The identifiers are: 0 = non-maskable pin, 1 = pin A, 2 = pin B, and 3+i = peripheral i.
- R5: In level mode (`cfg_x_edge` = 0), a general pin is pending exactly while it is low.
- R6: In edge mode (`cfg_x_edge` = 1), a high-to-low transition seen on two successive clock edges latches the request as pending. It stays pending after the pin returns high, until `ack` is sampled high while `irq_valid` = 1 and `irq_src` names that source.
- R7: The non-maskable pin is always edge-latched as in R6, and it always has level 3.
- R8: `irq_vector` is `VEC_NMI`, `VEC_A` or `VEC_B` for source 0, 1 or 2. For peripheral i it is the slice `per_vec[i*VEC_W +: VEC_W]`, taken at the cycle of evaluation.
- R9: All outputs are registered. They show the evaluation of the inputs and pending state as they stood at the previous clock edge. When no request is accepted, `irq_valid` = 0 and `irq_src`, `irq_level` and `irq_vector` all read 0.
- R10: On the first clock edge after `rst_n` rises, `mode_bits` captures the pins: bit 0 = pin A, bit 1 = pin B, bit 2 = the non-maskable pin. After that it holds its value until the next reset.
- R11: During reset, every output reads 0.
- R12: An `ack` while a level-mode or peripheral source is presented has no effect: that request stays presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_a_n | input | 1 | General request pin A, active low; mode bit 0 at reset release |
| pin_b_n | input | 1 | General request pin B, active low; mode bit 1 at reset release |
| pin_nmi_n | input | 1 | Non-maskable request pin, falling edge; mode bit 2 at reset release |
| cfg_a_edge | input | 1 | Pin A mode: 1 = falling edge, 0 = level |
| cfg_b_edge | input | 1 | Pin B mode: 1 = falling edge, 0 = level |
| lvl_a | input | 2 | Priority level of pin A |
| lvl_b | input | 2 | Priority level of pin B |
| mask_lvl | input | 2 | Current mask level from the status register |
| per_req | input | NUM_PERIPH | Peripheral request lines |
| per_lvl | input | 2*NUM_PERIPH | Peripheral levels, two bits per source |
| per_vec | input | VEC_W*NUM_PERIPH | Peripheral vector addresses |
| ack | input | 1 | Acknowledge pulse for the presented source |
| irq_valid | output | 1 | An accepted request is presented |
| irq_src | output | $clog2(NUM_PERIPH+3) | Winning source identifier |
| irq_level | output | 2 | Level of the winner |
| irq_vector | output | VEC_W | Vector address of the winner |
| mode_bits | output | 3 | Mode pins captured at reset release |

## Verification
The hardest case to reach is an edge-latched request that meets its own acknowledge. The pin must fall while in edge mode, then return high, and the request must win while the bench pulses `ack` against the presented source. The same cases are needed with a new falling edge landing in the acknowledge cycle, and with `ack` aimed at a level-mode or peripheral winner, which must not clear anything. Directed sequences build each of these cases once. A long random phase then adds biased pin pulses, mode flips and acknowledges of whatever is presented. A bench-side cycle model predicts every output word. The mode capture is checked across two resets with different pin patterns.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_TOP = 2'd3;

  localparam int ID_NMI  = 0;
  localparam int ID_A    = 1;
  localparam int ID_B    = 2;
  localparam int ID_PER0 = 3;

  // A level passes the mask when it reaches it; the top level always passes.
  function automatic logic lvl_accepted(lvl_t lvl, lvl_t mask);
    return (lvl == LVL_TOP) || (lvl >= mask);
  endfunction

  // A candidate displaces the current best only on a strictly higher level,
  // so the lower index survives a tie.
  function automatic logic outranks(lvl_t cand, lvl_t best, logic have_best);
    return !have_best || (cand > best);
  endfunction
endpackage

// File: rtl/irq_edge_src.sv
module irq_edge_src (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic pending,
  output logic latch_q
);
  logic prev_q;
  logic fall;

  assign fall = armed & prev_q & ~pin_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= pin_n;
      latch_q <= (edge_mode & fall) | (latch_q & ~clr);
    end
  end

  assign pending = edge_mode ? latch_q : ~pin_n;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_arb_pkg::*;
#(
  parameter int NSRC  = 7,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       req,
  input  logic [NSRC*LVL_W-1:0] lvl_flat,
  input  lvl_t                  mask,
  output logic [NSRC-1:0]       grant,
  output logic                  any,
  output logic [IDX_W-1:0]      win_idx,
  output lvl_t                  win_lvl
);
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && lvl_accepted(lvl_flat[i*LVL_W +: LVL_W], mask) &&
          outranks(lvl_flat[i*LVL_W +: LVL_W], win_lvl, any)) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
    grant = '0;
    if (any) grant[win_idx] = 1'b1;
  end
endmodule

// File: rtl/irq_mode_latch.sv
module irq_mode_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pins,
  output logic [2:0] mode,
  output logic       armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      mode  <= pins;
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int VEC_W      = 8,
  parameter logic [VEC_W-1:0] VEC_NMI = 8'h08,
  parameter logic [VEC_W-1:0] VEC_A   = 8'h10,
  parameter logic [VEC_W-1:0] VEC_B   = 8'h18,
  localparam int NSRC  = NUM_PERIPH + 3,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pin_a_n,
  input  logic                        pin_b_n,
  input  logic                        pin_nmi_n,
  input  logic                        cfg_a_edge,
  input  logic                        cfg_b_edge,
  input  logic [1:0]                  lvl_a,
  input  logic [1:0]                  lvl_b,
  input  logic [1:0]                  mask_lvl,
  input  logic [NUM_PERIPH-1:0]       per_req,
  input  logic [2*NUM_PERIPH-1:0]     per_lvl,
  input  logic [VEC_W*NUM_PERIPH-1:0] per_vec,
  input  logic                        ack,
  output logic                        irq_valid,
  output logic [IDX_W-1:0]            irq_src,
  output logic [1:0]                  irq_level,
  output logic [VEC_W-1:0]            irq_vector,
  output logic [2:0]                  mode_bits
);
  logic armed;
  logic pend_nmi, pend_a, pend_b;
  logic latch_nmi, latch_a, latch_b;
  logic clr_nmi, clr_a, clr_b;
  logic [NSRC-1:0]       req;
  logic [NSRC*LVL_W-1:0] lvl_flat;
  logic [NSRC-1:0]       grant;
  logic                  any_elig;
  logic [IDX_W-1:0]      win_idx;
  lvl_t                  win_lvl;
  logic [VEC_W-1:0]      win_vec;

  irq_mode_latch u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .pins ({pin_nmi_n, pin_b_n, pin_a_n}),
    .mode (mode_bits),
    .armed(armed)
  );

  // Acknowledge retires the latch of whichever source is on the outputs.
  assign clr_nmi = ack & irq_valid & (irq_src == IDX_W'(ID_NMI));
  assign clr_a   = ack & irq_valid & (irq_src == IDX_W'(ID_A));
  assign clr_b   = ack & irq_valid & (irq_src == IDX_W'(ID_B));

  irq_edge_src u_nmi (
    .clk(clk), .rst_n(rst_n), .armed(armed), .pin_n(pin_nmi_n),
    .edge_mode(1'b1), .clr(clr_nmi), .pending(pend_nmi), .latch_q(latch_nmi)
  );
  irq_edge_src u_pa (
    .clk(clk), .rst_n(rst_n), .armed(armed), .pin_n(pin_a_n),
    .edge_mode(cfg_a_edge), .clr(clr_a), .pending(pend_a), .latch_q(latch_a)
  );
  irq_edge_src u_pb (
    .clk(clk), .rst_n(rst_n), .armed(armed), .pin_n(pin_b_n),
    .edge_mode(cfg_b_edge), .clr(clr_b), .pending(pend_b), .latch_q(latch_b)
  );

  assign req[ID_NMI] = pend_nmi;
  assign req[ID_A]   = pend_a;
  assign req[ID_B]   = pend_b;
  assign lvl_flat[ID_NMI*LVL_W +: LVL_W] = LVL_TOP;
  assign lvl_flat[ID_A*LVL_W +: LVL_W]   = lvl_a;
  assign lvl_flat[ID_B*LVL_W +: LVL_W]   = lvl_b;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
    assign req[ID_PER0+p] = per_req[p];
    assign lvl_flat[(ID_PER0+p)*LVL_W +: LVL_W] = per_lvl[p*LVL_W +: LVL_W];
  end

  irq_prio_sel #(.NSRC(NSRC), .IDX_W(IDX_W)) u_sel (
    .req     (req),
    .lvl_flat(lvl_flat),
    .mask    (mask_lvl),
    .grant   (grant),
    .any     (any_elig),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  always_comb begin
    win_vec = '0;
    if (win_idx == IDX_W'(ID_NMI)) win_vec = VEC_NMI;
    if (win_idx == IDX_W'(ID_A))   win_vec = VEC_A;
    if (win_idx == IDX_W'(ID_B))   win_vec = VEC_B;
    for (int p = 0; p < NUM_PERIPH; p++) begin
      if (win_idx == IDX_W'(ID_PER0 + p)) win_vec = per_vec[p*VEC_W +: VEC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_src    <= '0;
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= any_elig;
      irq_src    <= any_elig ? win_idx : '0;
      irq_level  <= any_elig ? win_lvl : '0;
      irq_vector <= any_elig ? win_vec : '0;
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NSRC = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mask_lvl,
  input logic            irq_valid,
  input logic [1:0]      irq_level,
  input logic            nmi_pend,
  input logic            a_latch,
  input logic            a_clr,
  input logic [NSRC-1:0] grant,
  input logic            any_elig,
  input logic            armed,
  input logic [2:0]      mode_bits
);
  // R7: a pending non-maskable request is on the outputs at level 3 next cycle
  a_r7_nmi_top_level: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |=> (irq_valid && irq_level == 2'd3));

  // R1, R2: a presented level never falls below the mask it was judged against
  a_r1_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level == 2'd3 || irq_level >= $past(mask_lvl)));

  // R4: at most one source granted, and a grant exists whenever one is eligible
  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_elig == (|grant)));

  // R6: an edge latch survives every cycle without its own clear
  a_r6_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
    (a_latch && !a_clr) |=> a_latch);

  // R9: the output flag follows eligibility by exactly one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    any_elig |=> irq_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !any_elig |=> !irq_valid);

  // R10: the captured mode never moves once taken
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> $stable(mode_bits));
endmodule

bind irq_arbiter irq_arbiter_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mask_lvl (mask_lvl),
  .irq_valid(irq_valid),
  .irq_level(irq_level),
  .nmi_pend (pend_nmi),
  .a_latch  (latch_a),
  .a_clr    (clr_a),
  .grant    (grant),
  .any_elig (any_elig),
  .armed    (armed),
  .mode_bits(mode_bits)
);

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int VW = 8;
  localparam int NS = NP + 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n;
  logic pin_a_n, pin_b_n, pin_nmi_n, cfg_a_edge, cfg_b_edge, ack;
  logic [1:0] lvl_a, lvl_b, mask_lvl;
  logic [NP-1:0] per_req;
  logic [2*NP-1:0] per_lvl;
  logic [VW*NP-1:0] per_vec;
  logic irq_valid;
  logic [2:0] irq_src;
  logic [1:0] irq_level;
  logic [VW-1:0] irq_vector;
  logic [2:0] mode_bits;

  irq_arbiter #(.NUM_PERIPH(NP), .VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_a_n(pin_a_n), .pin_b_n(pin_b_n),
    .pin_nmi_n(pin_nmi_n), .cfg_a_edge(cfg_a_edge), .cfg_b_edge(cfg_b_edge),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .mask_lvl(mask_lvl), .per_req(per_req),
    .per_lvl(per_lvl), .per_vec(per_vec), .ack(ack), .irq_valid(irq_valid),
    .irq_src(irq_src), .irq_level(irq_level), .irq_vector(irq_vector),
    .mode_bits(mode_bits)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench-side state of the expected behaviour
  bit m_pa, m_pb, m_pn, m_prev_a, m_prev_b, m_prev_n, m_boot;
  logic [2:0] m_mode;
  bit o_valid;
  int o_src;

  // Winner search by descending level, then ascending identifier (R1-style rules restated).
  function automatic void pick(output bit v, output int s, output int l);
    bit rq[NS];
    int lv[NS];
    rq[0] = m_pn;                          lv[0] = 3;
    rq[1] = cfg_a_edge ? m_pa : !pin_a_n;  lv[1] = int'(lvl_a);
    rq[2] = cfg_b_edge ? m_pb : !pin_b_n;  lv[2] = int'(lvl_b);
    for (int k = 0; k < NP; k++) begin
      rq[3+k] = per_req[k];
      lv[3+k] = int'(per_lvl[2*k +: 2]);
    end
    v = 0; s = 0; l = 0;
    for (int lev = 3; lev >= 0; lev--) begin
      if (!v && (lev == 3 || lev >= int'(mask_lvl))) begin
        for (int k = 0; k < NS; k++) begin
          if (!v && rq[k] && lv[k] == lev) begin
            v = 1; s = k; l = lev;
          end
        end
      end
    end
  endfunction

  function automatic logic [VW-1:0] vec_of(int s);
    if (s == 0) return 8'h08;
    if (s == 1) return 8'h10;
    if (s == 2) return 8'h18;
    return per_vec[(s-3)*VW +: VW];
  endfunction

  task automatic fail_msg(string tag, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  // Called just after a falling edge with inputs settled; checks one cycle later.
  task automatic step(string tag);
    bit v;
    int s, l;
    logic [VW-1:0] ev;
    bit ca, cb, cn;
    pick(v, s, l);
    ev = v ? vec_of(s) : '0;
    ca = ack && o_valid && o_src == 1;
    cb = ack && o_valid && o_src == 2;
    cn = ack && o_valid && o_src == 0;
    m_pa = (m_boot && cfg_a_edge && m_prev_a && !pin_a_n) || (m_pa && !ca);
    m_pb = (m_boot && cfg_b_edge && m_prev_b && !pin_b_n) || (m_pb && !cb);
    m_pn = (m_boot && m_prev_n && !pin_nmi_n) || (m_pn && !cn);
    if (!m_boot) m_mode = {pin_nmi_n, pin_b_n, pin_a_n};
    m_boot = 1;
    m_prev_a = pin_a_n; m_prev_b = pin_b_n; m_prev_n = pin_nmi_n;
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (irq_valid !== v)         fail_msg(tag, "valid", int'(irq_valid), int'(v));
    else if (irq_src !== s[2:0]) fail_msg(tag, "src", int'(irq_src), s);
    else if (irq_level !== l[1:0]) fail_msg(tag, "level", int'(irq_level), l);
    else if (irq_vector !== ev)  fail_msg(tag, "vector", int'(irq_vector), int'(ev));
    o_valid = v;
    o_src = s;
  endtask

  task automatic quiet();
    pin_a_n = 1; pin_b_n = 1; pin_nmi_n = 1; ack = 0;
    cfg_a_edge = 0; cfg_b_edge = 0; lvl_a = 0; lvl_b = 0; mask_lvl = 0;
    per_req = '0; per_lvl = '0;
  endtask

  task automatic do_reset(logic [2:0] pat);
    @(negedge clk);
    rst_n = 0;
    quiet();
    {pin_nmi_n, pin_b_n, pin_a_n} = pat;
    repeat (3) @(negedge clk);
    n_vec++;  // R11: outputs idle during reset
    if (irq_valid !== 1'b0 || irq_src !== 3'd0 || irq_level !== 2'd0 || irq_vector !== 8'h00)
      fail_msg("R11", "reset outputs", int'({irq_valid, irq_src, irq_level, irq_vector}), 0);
    rst_n = 1;
    m_pa = 0; m_pb = 0; m_pn = 0; m_prev_a = 1; m_prev_b = 1; m_prev_n = 1;
    m_boot = 0; o_valid = 0; o_src = 0;
    step("R10");
    n_vec++;  // R10: mode pins captured at release
    if (mode_bits !== pat) fail_msg("R10", "mode capture", int'(mode_bits), int'(pat));
    quiet();
    step("R10");
  endtask

  task automatic rand_phase(int count);
    for (int i = 0; i < count; i++) begin
      pin_a_n   = ($urandom % 4) != 0;
      pin_b_n   = ($urandom % 4) != 0;
      pin_nmi_n = ($urandom % 8) != 0;
      if ($urandom % 16 == 0) cfg_a_edge = $urandom;
      if ($urandom % 16 == 0) cfg_b_edge = $urandom;
      lvl_a    = $urandom;
      lvl_b    = $urandom;
      mask_lvl = $urandom;
      per_req  = $urandom;
      per_lvl  = $urandom;
      per_vec  = $urandom;
      ack      = o_valid && ($urandom % 3 == 0);
      step("R3");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] mode_keep;
    void'($urandom(32'h5eed_1234));
    rst_n = 0;
    quiet();
    per_vec = {8'hC3, 8'hC2, 8'hC1, 8'hC0};
    do_reset(3'b101);

    // R1: level 1 peripheral refused at mask 2, accepted at mask 1 (R8 vector, R9 latency)
    per_req = 4'b0001; per_lvl = 8'b00_00_00_01; mask_lvl = 2;
    step("R1");
    mask_lvl = 1;
    step("R1");
    step("R8");

    // R3: level-mode pin A at 1 loses to peripheral 1 at 2
    per_req = 4'b0010; per_lvl = 8'b00_00_10_00; pin_a_n = 0; lvl_a = 1;
    step("R3");
    // R4: tie at level 2 among A, B and peripheral 1 goes to A
    lvl_a = 2; lvl_b = 2; pin_b_n = 0;
    step("R4");
    // R5: releasing A hands the win to B
    pin_a_n = 1;
    step("R5");
    pin_b_n = 1; per_req = '0;
    step("R5");

    // R6: edge mode on A: pulse, hold, ack, clear
    cfg_a_edge = 1; lvl_a = 1; mask_lvl = 0;
    pin_a_n = 0; step("R6");
    pin_a_n = 1; step("R6");
    step("R6");
    ack = 1; step("R6");
    ack = 0; step("R6");
    // R6: new fall landing in the ack cycle keeps the request
    pin_a_n = 0; step("R6");
    pin_a_n = 1; step("R6");
    ack = 1; pin_a_n = 0; step("R6");
    ack = 0; pin_a_n = 1; step("R6");
    step("R6");
    ack = 1; step("R6");
    ack = 0; step("R6");

    // R12: ack against a peripheral winner changes nothing
    per_req = 4'b0100; per_lvl = 8'b00_01_00_00;
    step("R12");
    ack = 1; step("R12");
    ack = 0; step("R12");
    // R12: ack against level-mode B changes nothing
    per_req = '0; pin_b_n = 0; lvl_b = 1;
    step("R12");
    ack = 1; step("R12");
    ack = 0; step("R12");
    pin_b_n = 1; step("R12");

    // R2: mask 3 refuses a level-2 peripheral but takes the non-maskable pin (R7)
    mask_lvl = 3; per_req = 4'b1000; per_lvl = 8'b10_00_00_00;
    step("R2");
    pin_nmi_n = 0; step("R7");
    pin_nmi_n = 1; step("R7");
    step("R2");
    ack = 1; step("R7");
    ack = 0; step("R7");

    quiet();
    mode_keep = mode_bits;
    rand_phase(3000);
    n_vec++;  // R10: mode unchanged by later pin activity
    if (mode_bits !== mode_keep) fail_msg("R10", "mode hold", int'(mode_bits), int'(mode_keep));

    do_reset(3'b010);
    rand_phase(500);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule